// File: doc/BRIEF.md
# Read Strobe Eye Sweep Window Finder

This block finds a read-strobe delay setting for several byte lanes at once. It steps a signed delay code through a fixed window, from the most negative code up to one below the matching positive code. For each step it asks an outside test to run and waits for that test's per-lane feedback. It keeps the longest unbroken run of passing codes for every lane. When the sweep is over it reports each lane's window start, end, width and center. It also reports a trained, unsigned delay code that goes to the rising-edge and falling-edge strobe delay outputs.

The sweep is run by a sequencer with six named states. `ST_IDLE` waits for `start_i`. `ST_INIT` clears the lane trackers, resets the step index and parks both strobe delays at the midpoint code. `ST_REQ` sends a one-cycle test request for the current code. `ST_WAIT` holds until the results strobe arrives. From `ST_WAIT` the sequencer goes back to `ST_REQ` with the next code, or to `ST_FINAL` after the last step. `ST_FINAL` latches the lane results and the trained delays. `ST_DONE` raises `done_o` for one cycle and returns to `ST_IDLE`. Trained codes reach the strobe delay outputs only in `ST_FINAL`, so the strobe delays do not move during the sweep.

A lane passes a step only when its feedback field holds exactly the value 1. A lane whose best window is too narrow is flagged, and any flagged lane raises the block-level failure output.

Top module: `rdeye_sweep`

## Requirements
- R1: After `start_i` in idle, `step_req_o` pulses once per step for a single cycle. Each pulse carries `step_code_o` (two's complement), and the codes run -32, -31, … +31 in order, which makes 64 steps.
- R2: The step advances only when `res_valid_i` is high while the block is waiting for results. A `res_valid_i` pulse at any other time does not change the step sequence.
- R3: A lane's step counts as a pass only if its 4-bit feedback field (lane k in bits [4k+3:4k] of `res_fb_i`) equals 1. Every other value is a fail.
- R4: Each lane keeps its longest contiguous run of passing codes. When two runs are the same length, the earlier one is kept. A run that is still open at the last step is closed at that step.
- R5: `win_start_o` and `win_end_o` give the first and last codes of the run, signed and 7 bits per lane. `win_width_o` (7 bits per lane) gives end − start + 1. `win_center_o` gives (start + end) shifted right arithmetically by one, which rounds toward minus infinity.
- R6: The trained code (6 bits per lane) is the center plus 32. The same trained code is driven on `dly_rise_o` and `dly_fall_o`.
- R7: Both strobe delay outputs hold the midpoint code 32 after reset, and they are set to 32 when a sweep starts. They do not change until the results are latched at the end of the sweep.
- R8: `lane_fail_o[k]` is set when lane k's width is 12 or less. `fail_o` is set when any lane fails.
- R9: A lane with no passing step reports width 0, start, end and center 0, and trained code 32, and it is flagged as failed.
- R10: `done_o` is high for exactly one cycle, two cycles after the results strobe for the last step is taken. The result outputs are valid from that cycle and hold until the next sweep latches new results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a sweep (accepted in idle) |
| done_o | output | 1 | One-cycle pulse, results valid |
| step_req_o | output | 1 | One-cycle request to run the test at the current code |
| step_code_o | output | 7 | Signed delay code under test |
| res_valid_i | input | 1 | Per-lane test feedback is valid |
| res_fb_i | input | 16 | Feedback, 4 bits per lane |
| win_start_o | output | 28 | Signed window start code per lane |
| win_end_o | output | 28 | Signed window end code per lane |
| win_center_o | output | 28 | Signed window center code per lane |
| win_width_o | output | 28 | Window width per lane |
| dly_rise_o | output | 24 | Rising-edge strobe delay code per lane |
| dly_fall_o | output | 24 | Falling-edge strobe delay code per lane |
| lane_fail_o | output | 4 | Per-lane narrow-window flag |
| fail_o | output | 1 | Any lane failed |

## Verification
The hardest cases to reach are the tie between two equal-length runs, a run that is still open when the sweep ends, and widths that sit exactly on the threshold of 12 and 13. Random feedback almost never produces any of these. The bench therefore builds pass patterns directly for each lane, including ties, a run that ends at +31, single-code windows and lanes with no pass at all. It mixes these with random run-structured patterns. Failing feedback uses random non-1 values so that only the exact-1 rule makes a step pass. The bench also waits a random number of cycles before each results strobe and sends stray strobes while the block is idle.

// File: rtl/rdeye_pkg.sv
package rdeye_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INIT,
        ST_REQ,
        ST_WAIT,
        ST_FINAL,
        ST_DONE
    } sweep_state_t;

endpackage

// File: rtl/rdeye_seq.sv
module rdeye_seq
    import rdeye_pkg::*;
#(
    parameter int STEP_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 res_valid_i,
    output logic                 step_req_o,
    output logic [STEP_BITS-1:0] step_idx_o,
    output logic                 clear_o,
    output logic                 record_o,
    output logic                 last_o,
    output logic                 latch_o,
    output logic                 active_o,
    output logic                 done_o
);

    localparam int STEPS = 1 << STEP_BITS;
    localparam logic [STEP_BITS-1:0] LAST_IDX = STEP_BITS'(STEPS - 1);

    sweep_state_t state, nxt;
    logic [STEP_BITS-1:0] idx;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start_i) nxt = ST_INIT;
            ST_INIT:  nxt = ST_REQ;
            ST_REQ:   nxt = ST_WAIT;
            ST_WAIT:  if (res_valid_i) nxt = (idx == LAST_IDX) ? ST_FINAL : ST_REQ;
            ST_FINAL: nxt = ST_DONE;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            state <= nxt;
            if (state == ST_INIT)
                idx <= '0;
            else if (state == ST_WAIT && res_valid_i && idx != LAST_IDX)
                idx <= idx + 1'b1;
        end
    end

    always_comb begin
        step_req_o = (state == ST_REQ);
        clear_o    = (state == ST_INIT);
        record_o   = (state == ST_WAIT) && res_valid_i;
        last_o     = (idx == LAST_IDX);
        latch_o    = (state == ST_FINAL);
        active_o   = (state == ST_REQ) || (state == ST_WAIT);
        done_o     = (state == ST_DONE);
        step_idx_o = idx;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        step_req_o |=> !step_req_o); // R1
    AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !res_valid_i) |=> ($stable(idx) && state == ST_WAIT)); // R2

endmodule

// File: rtl/rdeye_lane.sv
module rdeye_lane #(
    parameter int STEP_BITS = 6,
    parameter int FB_W      = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 record_i,
    input  logic                 last_i,
    input  logic [STEP_BITS-1:0] idx_i,
    input  logic [FB_W-1:0]      fb_i,
    output logic [STEP_BITS-1:0] best_start_o,
    output logic [STEP_BITS:0]   best_len_o
);

    localparam int LEN_W = STEP_BITS + 1;
    localparam int STEPS = 1 << STEP_BITS;

    logic                 in_run;
    logic [STEP_BITS-1:0] cur_start;
    logic [LEN_W-1:0]     cur_len;

    logic                 pass;
    logic [LEN_W-1:0]     ext_len;
    logic [STEP_BITS-1:0] ext_start;
    logic                 close_run;
    logic [LEN_W-1:0]     close_len;
    logic [STEP_BITS-1:0] close_start;
    logic                 take;

    always_comb begin
        pass        = (fb_i == FB_W'(1));
        ext_len     = in_run ? cur_len + 1'b1 : LEN_W'(1);
        ext_start   = in_run ? cur_start : idx_i;
        close_run   = record_i && ((pass && last_i) || (!pass && in_run));
        close_len   = pass ? ext_len : cur_len;
        close_start = pass ? ext_start : cur_start;
        take        = close_run && (close_len > best_len_o);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            in_run       <= 1'b0;
            cur_start    <= '0;
            cur_len      <= '0;
            best_start_o <= '0;
            best_len_o   <= '0;
        end else if (record_i) begin
            in_run    <= pass && !last_i;
            cur_len   <= pass ? ext_len : '0;
            cur_start <= pass ? ext_start : cur_start;
            if (take) begin
                best_start_o <= close_start;
                best_len_o   <= close_len;
            end
        end
    end

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        best_len_o <= LEN_W'(STEPS)); // R4
    AST_BEST_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        record_i |=> best_len_o >= $past(best_len_o)); // R4

endmodule

// File: rtl/rdeye_result.sv
module rdeye_result #(
    parameter int STEP_BITS = 6,
    parameter int MIN_WIDTH = 12
) (
    input  logic [STEP_BITS-1:0]        best_start_i,
    input  logic [STEP_BITS:0]          best_len_i,
    output logic signed [STEP_BITS:0]   start_code_o,
    output logic signed [STEP_BITS:0]   end_code_o,
    output logic signed [STEP_BITS:0]   center_code_o,
    output logic [STEP_BITS:0]          width_o,
    output logic [STEP_BITS-1:0]        trained_o,
    output logic                        fail_o
);

    localparam int CODE_W = STEP_BITS + 1;
    localparam int HALF   = 1 << (STEP_BITS - 1);
    localparam logic signed [CODE_W-1:0] HALF_S = CODE_W'(HALF);

    logic [CODE_W-1:0] end_idx;
    logic [CODE_W:0]   idx_sum;
    logic [STEP_BITS-1:0] mid_idx;

    always_comb begin
        end_idx = {1'b0, best_start_i} + best_len_i - 1'b1;
        idx_sum = {1'b0, end_idx} + {2'b00, best_start_i};
        mid_idx = idx_sum[STEP_BITS:1];
        width_o = best_len_i;
        fail_o  = (best_len_i <= CODE_W'(MIN_WIDTH));
        if (best_len_i == '0) begin
            start_code_o  = '0;
            end_code_o    = '0;
            center_code_o = '0;
            trained_o     = STEP_BITS'(HALF);
        end else begin
            start_code_o  = $signed({1'b0, best_start_i}) - HALF_S;
            end_code_o    = $signed(end_idx) - HALF_S;
            center_code_o = $signed({1'b0, mid_idx}) - HALF_S;
            trained_o     = mid_idx;
        end
    end

endmodule

// File: rtl/rdeye_sweep.sv
module rdeye_sweep #(
    parameter int NUM_LANES = 4,
    parameter int FB_W      = 4,
    parameter int STEP_BITS = 6,
    parameter int MIN_WIDTH = 12
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start_i,
    output logic                                 done_o,
    output logic                                 step_req_o,
    output logic [STEP_BITS:0]                   step_code_o,
    input  logic                                 res_valid_i,
    input  logic [NUM_LANES*FB_W-1:0]            res_fb_i,
    output logic [NUM_LANES*(STEP_BITS+1)-1:0]   win_start_o,
    output logic [NUM_LANES*(STEP_BITS+1)-1:0]   win_end_o,
    output logic [NUM_LANES*(STEP_BITS+1)-1:0]   win_center_o,
    output logic [NUM_LANES*(STEP_BITS+1)-1:0]   win_width_o,
    output logic [NUM_LANES*STEP_BITS-1:0]       dly_rise_o,
    output logic [NUM_LANES*STEP_BITS-1:0]       dly_fall_o,
    output logic [NUM_LANES-1:0]                 lane_fail_o,
    output logic                                 fail_o
);

    localparam int CODE_W = STEP_BITS + 1;
    localparam int HALF   = 1 << (STEP_BITS - 1);
    localparam logic [STEP_BITS-1:0] MID_CODE = STEP_BITS'(HALF);

    logic                 clear, record, last, latch, active;
    logic [STEP_BITS-1:0] step_idx;

    rdeye_seq #(.STEP_BITS(STEP_BITS)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .res_valid_i (res_valid_i),
        .step_req_o  (step_req_o),
        .step_idx_o  (step_idx),
        .clear_o     (clear),
        .record_o    (record),
        .last_o      (last),
        .latch_o     (latch),
        .active_o    (active),
        .done_o      (done_o)
    );

    assign step_code_o = $signed({1'b0, step_idx}) - CODE_W'(HALF);

    logic [NUM_LANES-1:0] fail_vec;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic [STEP_BITS-1:0]     best_start;
        logic [STEP_BITS:0]       best_len;
        logic signed [CODE_W-1:0] s_code, e_code, c_code;
        logic [CODE_W-1:0]        width;
        logic [STEP_BITS-1:0]     trained;

        rdeye_lane #(.STEP_BITS(STEP_BITS), .FB_W(FB_W)) u_lane (
            .clk          (clk),
            .rst_n        (rst_n),
            .clear_i      (clear),
            .record_i     (record),
            .last_i       (last),
            .idx_i        (step_idx),
            .fb_i         (res_fb_i[g*FB_W +: FB_W]),
            .best_start_o (best_start),
            .best_len_o   (best_len)
        );

        rdeye_result #(.STEP_BITS(STEP_BITS), .MIN_WIDTH(MIN_WIDTH)) u_res (
            .best_start_i  (best_start),
            .best_len_i    (best_len),
            .start_code_o  (s_code),
            .end_code_o    (e_code),
            .center_code_o (c_code),
            .width_o       (width),
            .trained_o     (trained),
            .fail_o        (fail_vec[g])
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_start_o[g*CODE_W +: CODE_W]     <= '0;
                win_end_o[g*CODE_W +: CODE_W]       <= '0;
                win_center_o[g*CODE_W +: CODE_W]    <= '0;
                win_width_o[g*CODE_W +: CODE_W]     <= '0;
                dly_rise_o[g*STEP_BITS +: STEP_BITS] <= MID_CODE;
                dly_fall_o[g*STEP_BITS +: STEP_BITS] <= MID_CODE;
            end else if (clear) begin
                dly_rise_o[g*STEP_BITS +: STEP_BITS] <= MID_CODE;
                dly_fall_o[g*STEP_BITS +: STEP_BITS] <= MID_CODE;
            end else if (latch) begin
                win_start_o[g*CODE_W +: CODE_W]     <= s_code;
                win_end_o[g*CODE_W +: CODE_W]       <= e_code;
                win_center_o[g*CODE_W +: CODE_W]    <= c_code;
                win_width_o[g*CODE_W +: CODE_W]     <= width;
                dly_rise_o[g*STEP_BITS +: STEP_BITS] <= trained;
                dly_fall_o[g*STEP_BITS +: STEP_BITS] <= trained;
            end
        end

        AST_NARROW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            (done_o && win_width_o[g*CODE_W +: CODE_W] <= CODE_W'(MIN_WIDTH))
                |-> (lane_fail_o[g] && fail_o)); // R8
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_fail_o <= '0;
            fail_o      <= 1'b0;
        end else if (latch) begin
            lane_fail_o <= fail_vec;
            fail_o      <= |fail_vec;
        end
    end

    AST_DLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> ($stable(dly_rise_o) && $stable(dly_fall_o))); // R7
    AST_EDGE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (dly_rise_o == dly_fall_o)); // R6

endmodule

// File: tb/rdeye_sweep_tb.sv
module rdeye_sweep_tb;

    localparam int NL = 4;
    localparam int FW = 4;
    localparam int SB = 6;
    localparam int CW = SB + 1;
    localparam int NS = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic res_valid_i = 1'b0;
    logic [NL*FW-1:0] res_fb_i = '0;
    logic done_o, step_req_o, fail_o;
    logic [CW-1:0] step_code_o;
    logic [NL*CW-1:0] win_start_o, win_end_o, win_center_o, win_width_o;
    logic [NL*SB-1:0] dly_rise_o, dly_fall_o;
    logic [NL-1:0] lane_fail_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [NS-1:0] pat [NL];

    always #5 clk = ~clk;

    rdeye_sweep u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
        .step_req_o(step_req_o), .step_code_o(step_code_o),
        .res_valid_i(res_valid_i), .res_fb_i(res_fb_i),
        .win_start_o(win_start_o), .win_end_o(win_end_o),
        .win_center_o(win_center_o), .win_width_o(win_width_o),
        .dly_rise_o(dly_rise_o), .dly_fall_o(dly_fall_o),
        .lane_fail_o(lane_fail_o), .fail_o(fail_o)
    );

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int fail_fb();
        int v;
        v = int'($urandom_range(0, 14));
        if (v >= 1) v = v + 1;
        return v;
    endfunction

    task automatic run_sweep();
        int bs [NL];
        int bl [NL];
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int s = 0; s < NS; s++) begin
            while (!step_req_o) @(negedge clk);
            check("R1 step code", int'($signed(step_code_o)), s - 32);
            check("R7 rise held mid", int'(dly_rise_o[0 +: SB]), 32);
            check("R7 fall held mid", int'(dly_fall_o[(NL-1)*SB +: SB]), 32);
            @(negedge clk);
            repeat ($urandom_range(0, 2)) @(negedge clk);
            for (int l = 0; l < NL; l++)
                res_fb_i[l*FW +: FW] = pat[l][s] ? FW'(1) : FW'(fail_fb());
            res_valid_i = 1'b1;
            @(negedge clk);
            res_valid_i = 1'b0;
        end
        for (int l = 0; l < NL; l++) begin
            int rs, rl;
            bs[l] = 0; bl[l] = 0; rs = 0; rl = 0;
            for (int s = 0; s < NS; s++) begin
                if (pat[l][s]) begin
                    if (rl == 0) rs = s;
                    rl++;
                end
                if ((!pat[l][s] || s == NS - 1) && rl > 0) begin
                    if (rl > bl[l]) begin bl[l] = rl; bs[l] = rs; end
                    rl = 0;
                end
            end
        end
        check("R10 done not early", int'(done_o), 0);
        @(negedge clk);
        check("R10 done on time", int'(done_o), 1);
        begin
            int anyf;
            anyf = 0;
            for (int l = 0; l < NL; l++) begin
                int es, ee, ec, et;
                if (bl[l] == 0) begin
                    es = 0; ee = 0; ec = 0; et = 32;
                    check("R9 empty width", int'(win_width_o[l*CW +: CW]), 0);
                end else begin
                    es = bs[l] - 32;
                    ee = bs[l] + bl[l] - 1 - 32;
                    ec = (bs[l] + bs[l] + bl[l] - 1) / 2 - 32;
                    et = ec + 32;
                end
                check("R4 R5 start", int'($signed(win_start_o[l*CW +: CW])), es);
                check("R4 R5 end", int'($signed(win_end_o[l*CW +: CW])), ee);
                check("R5 width", int'(win_width_o[l*CW +: CW]), bl[l]);
                check("R5 center", int'($signed(win_center_o[l*CW +: CW])), ec);
                check("R6 rise trained", int'(dly_rise_o[l*SB +: SB]), et);
                check("R6 fall trained", int'(dly_fall_o[l*SB +: SB]), et);
                check("R8 lane fail", int'(lane_fail_o[l]), (bl[l] <= 12) ? 1 : 0);
                if (bl[l] <= 12) anyf = 1;
            end
            check("R8 any fail", int'(fail_o), anyf);
        end
        @(negedge clk);
        check("R10 done single cycle", int'(done_o), 0);
        repeat (3) @(negedge clk);
        check("R10 results held", int'(win_width_o[0 +: CW]), bl[0]);
    endtask

    function automatic logic [NS-1:0] run_pat(int first, int len);
        logic [NS-1:0] p = '0;
        for (int s = first; s < first + len && s < NS; s++) p[s] = 1'b1;
        return p;
    endfunction

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        check("R7 reset rise mid", int'(dly_rise_o[0 +: SB]), 32);
        check("R7 reset fall mid", int'(dly_fall_o[SB +: SB]), 32);
        check("R10 reset done low", int'(done_o), 0);
        rst_n = 1'b1;
        // R2: stray strobes while idle must not move the step sequence
        @(negedge clk); res_valid_i = 1'b1;
        @(negedge clk); res_valid_i = 1'b0;
        @(negedge clk); res_valid_i = 1'b1;
        @(negedge clk); res_valid_i = 1'b0;
        check("R2 no req while idle", int'(step_req_o), 0);

        // all pass, none pass, tie (earlier kept), run open at last step
        pat[0] = '1;
        pat[1] = '0;
        pat[2] = run_pat(3, 10) | run_pat(30, 10);
        pat[3] = run_pat(50, 14);
        run_sweep();
        // R8 threshold 12 vs 13, single-code window, R3 random fail values
        pat[0] = run_pat(10, 12);
        pat[1] = run_pat(20, 13);
        pat[2] = run_pat(0, 1);
        pat[3] = run_pat(0, 20) | run_pat(40, 21);
        run_sweep();
        for (int r = 0; r < 6; r++) begin
            for (int l = 0; l < NL; l++) begin
                logic b;
                b = $urandom_range(0, 1) == 1;
                for (int s = 0; s < NS; s++) begin
                    if ($urandom_range(0, 5) == 0) b = ~b;
                    pat[l][s] = b;
                end
            end
            run_sweep();
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule